// File: doc/BRIEF.md
# Threshold-Gated Masked Priority Bus Arbiter

This block shares one bus among four DMA channels. Each channel owns a FIFO and moves data in one direction. A channel that fetches data into its FIFO asks for the bus once enough free space has opened. A channel that drains its FIFO to the bus asks once enough data has gathered. Both limits come from a 3-bit code in the channel's configuration word, counted in 32-byte steps. An idle channel below its limit never competes for the bus. This keeps small, wasteful bursts off the bus.

Among the channels that are requesting, the arbiter grants the lowest-numbered one that is not masked. It then masks that channel, so the others get their turn before it wins again. When no unmasked request is left, every mask drops at once and plain fixed priority applies again. A grant stays in force until the owning channel strobes its transfer-done line. After that the bus goes idle for one cycle and is then granted again.

Top module: `dma_bus_arbiter`

## Requirements
- R1: While `rst_n` is low, `grant` is 0 and `grant_valid` is 0, and all masks are cleared. Asserting `rst_n` low takes effect at once, with no clock edge. The first arbitration after reset therefore follows pure fixed priority.
- R2: A channel with `dir_rd` bit 0 (write direction) requests the bus only when its `fifo_fill` is strictly greater than (W+1)*32 bytes. W is bits 2:0 of that channel's 16-bit slice of `cfg_words`. Its `fifo_free` has no effect.
- R3: A channel with `dir_rd` bit 1 (read direction) requests the bus only when its `fifo_free` is strictly greater than (R+1)*32 bytes. R is bits 10:8 of that channel's configuration slice. Its `fifo_fill` has no effect.
- R4: When the bus is idle and an unmasked request exists, the grant goes to the unmasked requester with the lowest index. Channel 0 has the highest priority and channel 3 the lowest.
- R5: A channel that receives a grant is masked. It stays masked through later arbitrations for as long as some unmasked request is present at arbitration time.
- R6: When the bus is idle and no unmasked request exists, all masks clear together. If any request is present, the lowest-index requester is granted and becomes the only masked channel.
- R7: A grant stays unchanged while it is held, whatever the requests do. It is released only when the transfer-done bit of the granted channel is high. Done bits of other channels have no effect.
- R8: The grant drops at the clock edge that samples the owner's transfer-done bit. That edge is followed by one idle cycle. The next grant appears at the edge after that idle cycle.
- R9: `grant` is one-hot or all zero, with bit i meaning channel i. `grant_valid` is high exactly when `grant` is nonzero.
- R10: When the bus is idle, a grant appears at the next clock edge if any channel is requesting at that edge. If none is requesting, the bus stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cfg_words | input | NUM_CH*16 | Per-channel configuration word: write code in bits 2:0, read code in bits 10:8 |
| fifo_fill | input | NUM_CH*LVL_W | Per-channel FIFO occupancy in bytes |
| fifo_free | input | NUM_CH*LVL_W | Per-channel FIFO free space in bytes |
| dir_rd | input | NUM_CH | Per-channel direction: 1 read (fill FIFO), 0 write (drain FIFO) |
| xfer_done | input | NUM_CH | Per-channel transfer-done strobe |
| grant | output | NUM_CH | One-hot bus grant |
| grant_valid | output | 1 | High while a grant is held |

## Verification
Requests are formed combinationally from the levels. A grant therefore shows up on the first rising edge after the inputs change while the bus is idle. A release shows up on the first edge that samples the owner's done bit. The next grant comes one edge after that. The bench drives every input on the falling edge and reads the outputs on the following falling edge. Each expected value is placed exactly one register stage after its stimulus. The only exception is reset, which is read one time unit after `rst_n` falls because it acts asynchronously.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // Configuration word layout per channel
  localparam int CFG_W     = 16;
  localparam int WR_LSB    = 0;
  localparam int RD_LSB    = 8;
  localparam int CODE_W    = 3;
  // Threshold granule is 2**UNIT_LOG2 bytes
  localparam int UNIT_LOG2 = 5;
  // Width needed to hold (2**CODE_W) << UNIT_LOG2
  localparam int LIM_W     = CODE_W + UNIT_LOG2 + 1;
endpackage

// File: rtl/arb_req_gen.sv
module arb_req_gen
  import arb_pkg::*;
#(
  parameter int LVL_W = 11
) (
  input  logic [CFG_W-1:0] cfg_word,
  input  logic [LVL_W-1:0] fill_bytes,
  input  logic [LVL_W-1:0] free_bytes,
  input  logic             dir_rd,
  output logic             req
);
  localparam int CMP_W = (LVL_W > LIM_W) ? LVL_W : LIM_W;

  logic [CODE_W-1:0] wr_code;
  logic [CODE_W-1:0] rd_code;
  logic [LIM_W-1:0]  wr_lim;
  logic [LIM_W-1:0]  rd_lim;
  logic              wr_hit;
  logic              rd_hit;
  logic              cfg_unused;

  assign wr_code = cfg_word[WR_LSB +: CODE_W];
  assign rd_code = cfg_word[RD_LSB +: CODE_W];

  // Reserved configuration bits are not decoded
  assign cfg_unused = ^{cfg_word[CFG_W-1:RD_LSB+CODE_W],
                        cfg_word[RD_LSB-1:WR_LSB+CODE_W]};

  // Limit = (code + 1) granules
  assign wr_lim = (LIM_W'(wr_code) + LIM_W'(1)) << UNIT_LOG2;
  assign rd_lim = (LIM_W'(rd_code) + LIM_W'(1)) << UNIT_LOG2;

  assign wr_hit = CMP_W'(fill_bytes) > CMP_W'(wr_lim);
  assign rd_hit = CMP_W'(free_bytes) > CMP_W'(rd_lim);

  assign req = dir_rd ? rd_hit : wr_hit;
endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] cand,
  output logic [N-1:0] pick_oh
);
  logic [N-1:0] lower_any;

  assign lower_any[0] = 1'b0;

  generate
    for (genvar g = 1; g < N; g++) begin : g_chain
      assign lower_any[g] = lower_any[g-1] | cand[g-1];
    end
  endgenerate

  assign pick_oh = cand & ~lower_any;
endmodule

// File: rtl/arb_mask_ctl.sv
module arb_mask_ctl #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  input  logic [N-1:0] mask_q,
  output logic [N-1:0] pick_oh,
  output logic [N-1:0] mask_upd
);
  logic [N-1:0] eligible;
  logic         none_open;
  logic [N-1:0] cand;

  assign eligible  = req & ~mask_q;
  assign none_open = ~|eligible;
  assign cand      = none_open ? req : eligible;

  arb_pick #(.N(N)) u_pick (
    .cand    (cand),
    .pick_oh (pick_oh)
  );

  assign mask_upd = (none_open ? '0 : mask_q) | pick_oh;
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int LVL_W  = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH*CFG_W-1:0] cfg_words,
  input  logic [NUM_CH*LVL_W-1:0] fifo_fill,
  input  logic [NUM_CH*LVL_W-1:0] fifo_free,
  input  logic [NUM_CH-1:0]       dir_rd,
  input  logic [NUM_CH-1:0]       xfer_done,
  output logic [NUM_CH-1:0]       grant,
  output logic                    grant_valid
);
  logic [NUM_CH-1:0] req_vec;
  logic [NUM_CH-1:0] pick_oh;
  logic [NUM_CH-1:0] mask_upd;
  logic [NUM_CH-1:0] grant_q, grant_d;
  logic [NUM_CH-1:0] mask_q, mask_d;
  logic              bus_idle;
  logic              release_hit;
  logic              upd_en;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_req
      arb_req_gen #(.LVL_W(LVL_W)) u_req (
        .cfg_word   (cfg_words[c*CFG_W +: CFG_W]),
        .fill_bytes (fifo_fill[c*LVL_W +: LVL_W]),
        .free_bytes (fifo_free[c*LVL_W +: LVL_W]),
        .dir_rd     (dir_rd[c]),
        .req        (req_vec[c])
      );
    end
  endgenerate

  arb_mask_ctl #(.N(NUM_CH)) u_mask (
    .req      (req_vec),
    .mask_q   (mask_q),
    .pick_oh  (pick_oh),
    .mask_upd (mask_upd)
  );

  assign bus_idle    = ~|grant_q;
  assign release_hit = |(grant_q & xfer_done);
  assign upd_en      = bus_idle | release_hit;

  // Next state
  always_comb begin
    grant_d = grant_q;
    mask_d  = mask_q;
    if (bus_idle) begin
      grant_d = pick_oh;
      mask_d  = mask_upd;
    end else if (release_hit) begin
      grant_d = '0;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      mask_q  <= '0;
    end else if (upd_en) begin
      grant_q <= grant_d;
      mask_q  <= mask_d;
    end
  end

  assign grant       = grant_q;
  assign grant_valid = |grant_q;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req,
  input logic [N-1:0] mask_q,
  input logic [N-1:0] xfer_done,
  input logic [N-1:0] grant,
  input logic         grant_valid
);
  AST_GRANT_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R9

  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && ((grant & xfer_done) == '0)) |=> $stable(grant)); // R7

  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & xfer_done) != '0) |=> !grant_valid); // R8

  AST_IDLE_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid && (req != '0)) |=> grant_valid); // R10

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid && (req == '0)) |=> !grant_valid); // R10

  AST_PICK_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid && ((req & ~mask_q) != '0))
      |=> ((grant & $past(req & ~mask_q)) == grant)); // R4

  AST_PICK_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid && ((req & ~mask_q) != '0))
      |=> (((grant - N'(1)) & $past(req & ~mask_q)) == '0)); // R4

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) |-> ((mask_q & grant) == grant)); // R5

  AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid && ((req & ~mask_q) == '0))
      |=> ((mask_q & ~grant) == '0)); // R6
endmodule

bind dma_bus_arbiter arb_checker #(.N(NUM_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req         (req_vec),
  .mask_q      (mask_q),
  .xfer_done   (xfer_done),
  .grant       (grant),
  .grant_valid (grant_valid)
);

// File: tb/dma_bus_arbiter_tb.sv
module dma_bus_arbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 4;
  localparam int LW         = 11;
  localparam int CW         = 16;

  // {request pattern, expected grant}
  localparam logic [7:0] VEC [10] = '{
    {4'b1111, 4'b0001}, {4'b1111, 4'b0010}, {4'b0011, 4'b0001},
    {4'b1001, 4'b1000}, {4'b0101, 4'b0100}, {4'b0000, 4'b0000},
    {4'b0100, 4'b0100}, {4'b0110, 4'b0010}, {4'b1110, 4'b1000},
    {4'b0110, 4'b0010}
  };

  logic              clk;
  logic              rst_n;
  logic [NCH*CW-1:0] cfg_words;
  logic [NCH*LW-1:0] fifo_fill;
  logic [NCH*LW-1:0] fifo_free;
  logic [NCH-1:0]    dir_rd;
  logic [NCH-1:0]    xfer_done;
  logic [NCH-1:0]    grant;
  logic              grant_valid;

  logic [CW-1:0] cfg_a  [NCH];
  logic [LW-1:0] fill_a [NCH];
  logic [LW-1:0] free_a [NCH];

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      cfg_words[c*CW +: CW] = cfg_a[c];
      fifo_fill[c*LW +: LW] = fill_a[c];
      fifo_free[c*LW +: LW] = free_a[c];
    end
  end

  dma_bus_arbiter #(.NUM_CH(NCH), .LVL_W(LW)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_words   (cfg_words),
    .fifo_fill   (fifo_fill),
    .fifo_free   (fifo_free),
    .dir_rd      (dir_rd),
    .xfer_done   (xfer_done),
    .grant       (grant),
    .grant_valid (grant_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp || grant_valid !== (exp != 4'b0)) begin
      n_fail++;
      $display("FAIL %s: grant=%b valid=%b expected grant=%b valid=%b",
               tag, act, grant_valid, exp, (exp != 4'b0));
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Write codes 1 (64 B), read codes 2 (96 B); pattern bit raises that channel
  task automatic drive_pattern(input logic [3:0] pat);
    for (int c = 0; c < NCH; c++) begin
      cfg_a[c] = 16'h0201;
      if (dir_rd[c]) begin
        fill_a[c] = 11'd1000;
        free_a[c] = pat[c] ? 11'd97 : 11'd96;
      end else begin
        free_a[c] = 11'd1000;
        fill_a[c] = pat[c] ? 11'd65 : 11'd64;
      end
    end
  endtask

  task automatic release_ch(input logic [3:0] ch, input string tag);
    xfer_done = ch;
    step();
    chk(tag, grant, 4'b0000);
    xfer_done = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    xfer_done = '0;
    dir_rd    = 4'b1010;
    drive_pattern(4'b1111);
    repeat (3) @(negedge clk);
    chk("R1 reset holds grant low", grant, 4'b0000);
    drive_pattern(4'b0000);
    rst_n = 1'b1;
    step();
    chk("R1 R10 idle after reset with no request", grant, 4'b0000);

    // Table walk: masked fixed priority
    foreach (VEC[i]) begin
      drive_pattern(VEC[i][7:4]);
      step();
      chk($sformatf("R4 R5 R6 vector %0d", i), grant, VEC[i][3:0]);
      if (VEC[i][3:0] != 4'b0)
        release_ch(VEC[i][3:0], "R8 release after done");
    end

    // R7: hold through foreign done and vanishing requests; mask now 0010
    drive_pattern(4'b1111);
    step();
    chk("R4 grant with mask 0010", grant, 4'b0001);
    xfer_done = 4'b1100;
    step();
    chk("R7 foreign done ignored", grant, 4'b0001);
    xfer_done = '0;
    drive_pattern(4'b0000);
    step();
    chk("R7 hold when requests vanish", grant, 4'b0001);
    drive_pattern(4'b1111);
    release_ch(4'b0001, "R8 grant drops on done edge");
    step();
    chk("R8 R5 regrant after idle cycle", grant, 4'b0100);
    release_ch(4'b0100, "R8 release ch2");

    // R2: write thresholds, strict compare
    drive_pattern(4'b0000);
    step();
    cfg_a[2]  = 16'h0207;
    fill_a[2] = 11'd256;
    step();
    chk("R2 code 7 at 256 bytes no request", grant, 4'b0000);
    fill_a[2] = 11'd257;
    step();
    chk("R2 code 7 above 256 bytes", grant, 4'b0100);
    release_ch(4'b0100, "R8 release ch2");
    drive_pattern(4'b0000);
    cfg_a[0]  = 16'h0200;
    fill_a[0] = 11'd32;
    step();
    chk("R2 code 0 at 32 bytes no request", grant, 4'b0000);
    fill_a[0] = 11'd33;
    step();
    chk("R2 code 0 above 32 bytes", grant, 4'b0001);
    release_ch(4'b0001, "R8 release ch0");

    // R3: read thresholds from bits 10:8, fill ignored
    drive_pattern(4'b0000);
    cfg_a[1]  = 16'h0700;
    free_a[1] = 11'd256;
    step();
    chk("R3 read code 7 at 256 free no request", grant, 4'b0000);
    free_a[1] = 11'd257;
    step();
    chk("R3 read code 7 above 256 free", grant, 4'b0010);
    release_ch(4'b0010, "R8 release ch1");

    // R2: write-direction channel ignores free space
    drive_pattern(4'b0000);
    dir_rd    = 4'b0010;
    fill_a[3] = 11'd0;
    free_a[3] = 11'd1000;
    step();
    chk("R2 write channel ignores free space", grant, 4'b0000);
    fill_a[3] = 11'd65;
    step();
    chk("R2 write channel fill above limit", grant, 4'b1000);
    release_ch(4'b1000, "R8 release ch3");
    dir_rd = 4'b1010;

    // R1: asynchronous reset mid-grant clears masks
    drive_pattern(4'b0000);
    step();
    drive_pattern(4'b0001);
    step();
    chk("R4 single request ch0", grant, 4'b0001);
    release_ch(4'b0001, "R8 release ch0");
    drive_pattern(4'b0011);
    step();
    chk("R5 ch0 masked so ch1 wins", grant, 4'b0010);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset clears grant", grant, 4'b0000);
    @(negedge clk);
    drive_pattern(4'b0111);
    rst_n = 1'b1;
    step();
    chk("R1 masks cleared by reset", grant, 4'b0001);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule